// File: doc/BRIEF.md
# 24-bit Instruction Field Decoder

This block is purely combinational. It takes one fixed-width 24-bit instruction word and splits it into an opcode, register indices and a 12-bit immediate. It sorts the word into one of four classes: plain ALU, multiply/divide, memory access, or control transfer. For the execute stage it produces the operation code, the choice between a register and an immediate operand, the extended 24-bit immediate, memory direction and width, the branch condition, and a jump flag.

The multiply/divide group has no opcodes of its own. It sits inside the ALU opcode space and is picked out by register-A codes whose two top bits are both set. For these words the real A register is rebuilt from an opcode bit and the two low A bits. Encodings that are reserved or not implemented raise `illegal_o`. The other outputs still carry the raw decode for such words, and the pipeline is expected to trap on `illegal_o`.

Top module: `instr_field_decoder`

## Requirements
- R1: `ra_o` = insn[18:15], `rd_o` = insn[14:12] and `rb_o` = insn[11:9] for every class except multiply/divide.
- R2: `cls_o` holds one of four values. 0 is ALU: insn[23]=0 and insn[18:17]≠11. 1 is multiply/divide: insn[23]=0 and insn[18:17]=11. 2 is memory: insn[23:22]=10. 3 is control: insn[23:22]=11.
- R3: For ALU words, `alu_op_o` follows insn[22:20]. 000 gives ADD(0). 001 gives LUI(8) when insn[19]=0 and SUB(1) when insn[19]=1. 010 gives SLL(2), 011 SRL(3), 100 SRA(4), 101 XOR(5), 110 OR(6) and 111 AND(7).
- R4: For multiply/divide words, insn[22:21] selects the operation: 00 gives MULLO(9), 01 MULHI(10), 10 DIVQ(11) and 11 DIVR(12). `ra_o` = {0, insn[20], insn[16:15]}.
- R5: For ALU and multiply/divide words, `use_imm_o` = 1 exactly when insn[19] = 0.
- R6: Opcode 00010 with A = 1000 is LUI. In that case `imm_o` = {insn[11:0], 12'h000}.
- R7: The immediate is sign-extended (`imm_sext_o`=1) for add, multiply, memory and conditional branch words. It is zero-extended for shift, logic, divide and jump words.
- R8: For memory words, `mem_store_o` = insn[20] and `mem_double_o` = insn[21]. The operation is ADD and `use_imm_o` = 1.
- R9: For control words, `br_cond_o` = insn[21:19]. `is_jump_o` = 1 when insn[23:20] = 1111 and insn[14:12] = 100. A jump uses ADD, and takes an immediate only when insn[19]=0. Any other control word is a branch: it uses SUB and always takes the immediate.
- R10: `illegal_o` = 1 in three cases: a memory word with insn[19]=1; opcode 00010 outside the multiply/divide pattern with A ≠ 1000; a memory or control word with A ≥ 1100.
- R11: With `STRICT_PAD`=1, a register-form word (ALU or multiply/divide with insn[19]=1, or a register jump) whose insn[8:0] ≠ 0 is illegal. With `STRICT_PAD`=0 those padding bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 24 | Instruction word |
| cls_o | output | 2 | Instruction class |
| alu_op_o | output | 4 | Operation code for the execute stage |
| use_imm_o | output | 1 | Second operand is the immediate |
| imm_sext_o | output | 1 | Immediate is sign-extended |
| imm_o | output | 24 | Extended or placed immediate |
| ra_o | output | 4 | Source register A (rebuilt for multiply/divide) |
| rd_o | output | 3 | Destination register |
| rb_o | output | 3 | Source register B |
| mem_store_o | output | 1 | Memory word is a store |
| mem_double_o | output | 1 | Memory word moves a double |
| br_cond_o | output | 3 | Branch condition code |
| is_jump_o | output | 1 | Control word is an absolute jump |
| illegal_o | output | 1 | Reserved or unimplemented encoding |

## Verification
The bench builds two copies of the decoder with the default widths. One has `STRICT_PAD`=1 and the other `STRICT_PAD`=0, so the same register-form word with dirty padding can be seen flagged by one copy and accepted by the other. That exercises both generate branches of the padding check. With the default field widths, every opcode, every multiply/divide selector, and the A-code boundary at 1011/1100 can be driven directly.

// File: rtl/idec_pkg.sv
package idec_pkg;
   typedef enum logic [1:0] {
      CLS_ALU    = 2'd0,
      CLS_MULDIV = 2'd1,
      CLS_MEM    = 2'd2,
      CLS_CTRL   = 2'd3
   } cls_e;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_SUB   = 4'd1,
      OP_SLL   = 4'd2,
      OP_SRL   = 4'd3,
      OP_SRA   = 4'd4,
      OP_XOR   = 4'd5,
      OP_OR    = 4'd6,
      OP_AND   = 4'd7,
      OP_LUI   = 4'd8,
      OP_MULLO = 4'd9,
      OP_MULHI = 4'd10,
      OP_DIVQ  = 4'd11,
      OP_DIVR  = 4'd12
   } aluop_e;
endpackage

// File: rtl/idec_fields.sv
module idec_fields #(
   parameter int INSN_W = 24,
   parameter int OPC_W  = 5,
   parameter int RA_W   = 4,
   parameter int R_W    = 3,
   parameter int IMM_W  = 12
) (
   input  logic [INSN_W-1:0] insn_i,
   output logic [OPC_W-1:0]  opc_o,
   output logic [RA_W-1:0]   ra_o,
   output logic [R_W-1:0]    rd_o,
   output logic [R_W-1:0]    rb_o,
   output logic [IMM_W-1:0]  imm_o,
   output logic              pad_nz_o
);
   localparam int RD_LSB  = IMM_W;
   localparam int RA_LSB  = RD_LSB + R_W;
   localparam int OPC_LSB = RA_LSB + RA_W;
   localparam int PAD_W   = IMM_W - R_W;

   assign opc_o    = insn_i[OPC_LSB +: OPC_W];
   assign ra_o     = insn_i[RA_LSB +: RA_W];
   assign rd_o     = insn_i[RD_LSB +: R_W];
   assign rb_o     = insn_i[PAD_W +: R_W];
   assign imm_o    = insn_i[IMM_W-1:0];
   assign pad_nz_o = |insn_i[PAD_W-1:0];
endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl
   import idec_pkg::*;
#(
   parameter int OPC_W      = 5,
   parameter int RA_W       = 4,
   parameter int R_W        = 3,
   parameter bit STRICT_PAD = 1'b1
) (
   input  logic [OPC_W-1:0] opc_i,
   input  logic [RA_W-1:0]  ra_i,
   input  logic [R_W-1:0]   rd_i,
   input  logic             pad_nz_i,
   output cls_e             cls_o,
   output aluop_e           op_o,
   output logic             use_imm_o,
   output logic             sext_o,
   output logic             lui_o,
   output logic             store_o,
   output logic             dbl_o,
   output logic [OPC_W-3:0] cond_o,
   output logic             jump_o,
   output logic [RA_W-1:0]  ra_eff_o,
   output logic             illegal_o
);
   localparam logic [RA_W-1:0] LUI_A    = RA_W'(8);
   localparam logic [R_W-1:0]  JUMP_SEL = R_W'(4);
   localparam int              RSV_MSB  = RA_W - 1;

   logic enc_bad;
   logic reg_form;
   logic pad_bad;
   logic a_rsv;

   assign a_rsv = &ra_i[RSV_MSB -: 2];

   always_comb begin
      cls_o     = CLS_ALU;
      op_o      = OP_ADD;
      use_imm_o = ~opc_i[0];
      sext_o    = 1'b0;
      lui_o     = 1'b0;
      store_o   = 1'b0;
      dbl_o     = 1'b0;
      cond_o    = '0;
      jump_o    = 1'b0;
      ra_eff_o  = ra_i;
      enc_bad   = 1'b0;
      reg_form  = 1'b0;
      if (!opc_i[4]) begin
         reg_form = opc_i[0];
         if (a_rsv) begin
            cls_o    = CLS_MULDIV;
            sext_o   = ~opc_i[3];
            ra_eff_o = {1'b0, opc_i[1], ra_i[1:0]};
            unique case (opc_i[3:2])
               2'b00:   op_o = OP_MULLO;
               2'b01:   op_o = OP_MULHI;
               2'b10:   op_o = OP_DIVQ;
               default: op_o = OP_DIVR;
            endcase
         end else begin
            unique case (opc_i[3:1])
               3'b000: begin op_o = OP_ADD; sext_o = 1'b1; end
               3'b001: begin
                  if (opc_i[0]) op_o = OP_SUB;
                  else begin
                     op_o    = OP_LUI;
                     lui_o   = 1'b1;
                     enc_bad = (ra_i != LUI_A);
                  end
               end
               3'b010:  op_o = OP_SLL;
               3'b011:  op_o = OP_SRL;
               3'b100:  op_o = OP_SRA;
               3'b101:  op_o = OP_XOR;
               3'b110:  op_o = OP_OR;
               default: op_o = OP_AND;
            endcase
         end
      end else if (!opc_i[3]) begin
         cls_o     = CLS_MEM;
         use_imm_o = 1'b1;
         sext_o    = 1'b1;
         store_o   = opc_i[1];
         dbl_o     = opc_i[2];
         enc_bad   = opc_i[0] | a_rsv;
      end else begin
         cls_o   = CLS_CTRL;
         cond_o  = opc_i[2:0];
         jump_o  = (&opc_i[2:1]) && (rd_i == JUMP_SEL);
         enc_bad = a_rsv;
         if (jump_o) begin
            reg_form = opc_i[0];
         end else begin
            op_o      = OP_SUB;
            use_imm_o = 1'b1;
            sext_o    = 1'b1;
         end
      end
   end

   generate
      if (STRICT_PAD) begin : g_pad_strict
         assign pad_bad = reg_form & pad_nz_i;
      end else begin : g_pad_lax
         assign pad_bad = 1'b0;
      end
   endgenerate

   assign illegal_o = enc_bad | pad_bad;

   always_comb begin
      // R10: every memory word with the low opcode bit set is rejected
      a_r10_mem_odd: assert (!(cls_o == CLS_MEM && opc_i[0]) || illegal_o)
         else $error("odd memory opcode not flagged");
   end
endmodule

// File: rtl/idec_immext.sv
module idec_immext #(
   parameter int IMM_W = 12,
   parameter int XLEN  = 24
) (
   input  logic [IMM_W-1:0] imm_i,
   input  logic             sext_i,
   input  logic             lui_i,
   output logic [XLEN-1:0]  val_o
);
   localparam int EXT_W = XLEN - IMM_W;

   always_comb begin
      if (lui_i)       val_o = {imm_i, {EXT_W{1'b0}}};
      else if (sext_i) val_o = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
      else             val_o = {{EXT_W{1'b0}}, imm_i};
   end
endmodule

// File: rtl/instr_field_decoder.sv
module instr_field_decoder
   import idec_pkg::*;
#(
   parameter int INSN_W     = 24,
   parameter int OPC_W      = 5,
   parameter int RA_W       = 4,
   parameter int R_W        = 3,
   parameter int IMM_W      = 12,
   parameter int XLEN       = 24,
   parameter bit STRICT_PAD = 1'b1
) (
   input  logic [INSN_W-1:0] insn_i,
   output logic [1:0]        cls_o,
   output logic [3:0]        alu_op_o,
   output logic              use_imm_o,
   output logic              imm_sext_o,
   output logic [XLEN-1:0]   imm_o,
   output logic [RA_W-1:0]   ra_o,
   output logic [R_W-1:0]    rd_o,
   output logic [R_W-1:0]    rb_o,
   output logic              mem_store_o,
   output logic              mem_double_o,
   output logic [OPC_W-3:0]  br_cond_o,
   output logic              is_jump_o,
   output logic              illegal_o
);
   localparam int FIELD_SUM = OPC_W + RA_W + R_W + IMM_W;

   generate
      if (FIELD_SUM != INSN_W) begin : g_chk_width
         $error("field widths do not add up to INSN_W");
      end
      if (XLEN <= IMM_W) begin : g_chk_xlen
         $error("XLEN must exceed IMM_W");
      end
      if (OPC_W != 5 || RA_W != 4 || R_W != 3) begin : g_chk_enc
         $error("opcode map needs OPC_W=5, RA_W=4, R_W=3");
      end
   endgenerate

   logic [OPC_W-1:0] opc;
   logic [RA_W-1:0]  ra_raw;
   logic [IMM_W-1:0] imm_raw;
   logic             pad_nz;
   logic             lui;
   cls_e             cls;
   aluop_e           op;

   idec_fields #(
      .INSN_W(INSN_W), .OPC_W(OPC_W), .RA_W(RA_W), .R_W(R_W), .IMM_W(IMM_W)
   ) u_fields (
      .insn_i(insn_i), .opc_o(opc), .ra_o(ra_raw), .rd_o(rd_o),
      .rb_o(rb_o), .imm_o(imm_raw), .pad_nz_o(pad_nz)
   );

   idec_ctrl #(
      .OPC_W(OPC_W), .RA_W(RA_W), .R_W(R_W), .STRICT_PAD(STRICT_PAD)
   ) u_ctrl (
      .opc_i(opc), .ra_i(ra_raw), .rd_i(rd_o), .pad_nz_i(pad_nz),
      .cls_o(cls), .op_o(op), .use_imm_o(use_imm_o), .sext_o(imm_sext_o),
      .lui_o(lui), .store_o(mem_store_o), .dbl_o(mem_double_o),
      .cond_o(br_cond_o), .jump_o(is_jump_o), .ra_eff_o(ra_o),
      .illegal_o(illegal_o)
   );

   idec_immext #(.IMM_W(IMM_W), .XLEN(XLEN)) u_immext (
      .imm_i(imm_raw), .sext_i(imm_sext_o), .lui_i(lui), .val_o(imm_o)
   );

   assign cls_o    = cls;
   assign alu_op_o = op;

   always_comb begin
      // R4: a rebuilt multiply/divide A index never reaches the reserved half
      a_r4_muldiv_ra: assert (cls != CLS_MULDIV || !ra_o[RA_W-1])
         else $error("multiply/divide A index out of range");
      // R6: a placed upper immediate leaves the low part clear
      a_r6_lui_low: assert (!lui || imm_o[XLEN-IMM_W-1:0] == '0)
         else $error("upper immediate low bits not clear");
      // R7: zero-extended immediates have an empty top part
      a_r7_zext_top: assert (imm_sext_o || lui || imm_o[XLEN-1:IMM_W] == '0)
         else $error("zero extension leaked into top bits");
      // R8: memory words address with an immediate offset and ADD
      a_r8_mem_addr: assert (cls != CLS_MEM || (use_imm_o && op == OP_ADD))
         else $error("memory word without immediate add");
      // R9: a jump is always a control word
      a_r9_jump_ctrl: assert (!is_jump_o || cls == CLS_CTRL)
         else $error("jump flag outside control class");
   end
endmodule

// File: tb/test_instr_field_decoder.sv
module test_instr_field_decoder;
   logic        clk = 1'b0;
   logic [23:0] insn = '0;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   logic [1:0]  cls;
   logic [3:0]  op;
   logic        use_imm, sext, st, dbl, jmp, ill;
   logic [23:0] imm;
   logic [3:0]  ra;
   logic [2:0]  rd, rb, cond;

   logic [1:0]  l_cls;
   logic [3:0]  l_op;
   logic        l_use_imm, l_sext, l_st, l_dbl, l_jmp, l_ill;
   logic [23:0] l_imm;
   logic [3:0]  l_ra;
   logic [2:0]  l_rd, l_rb, l_cond;

   instr_field_decoder i_instr_field_decoder (
      .insn_i(insn), .cls_o(cls), .alu_op_o(op), .use_imm_o(use_imm),
      .imm_sext_o(sext), .imm_o(imm), .ra_o(ra), .rd_o(rd), .rb_o(rb),
      .mem_store_o(st), .mem_double_o(dbl), .br_cond_o(cond),
      .is_jump_o(jmp), .illegal_o(ill)
   );

   instr_field_decoder #(.STRICT_PAD(1'b0)) i_instr_field_decoder_lax (
      .insn_i(insn), .cls_o(l_cls), .alu_op_o(l_op), .use_imm_o(l_use_imm),
      .imm_sext_o(l_sext), .imm_o(l_imm), .ra_o(l_ra), .rd_o(l_rd), .rb_o(l_rb),
      .mem_store_o(l_st), .mem_double_o(l_dbl), .br_cond_o(l_cond),
      .is_jump_o(l_jmp), .illegal_o(l_ill)
   );

   function automatic logic [23:0] mk(input logic [4:0] o, input logic [3:0] a,
                                      input logic [2:0] d, input logic [11:0] lo);
      return {o, a, d, lo};
   endfunction

   function automatic logic [3:0] alu_exp(input logic [4:0] o);
      case (o[3:1])
         3'd0: return 4'd0;
         3'd1: return o[0] ? 4'd1 : 4'd8;
         3'd2: return 4'd2;
         3'd3: return 4'd3;
         3'd4: return 4'd4;
         3'd5: return 4'd5;
         3'd6: return 4'd6;
         default: return 4'd7;
      endcase
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [23:0] v);
      @(negedge clk);
      insn = v;
      #1;
   endtask

   task automatic t_idle;
      drive(24'h000000);
      chk("R2", "nop class", 32'(cls), 0);
      chk("R3", "nop op", 32'(op), 0);
      chk("R7", "nop sext", 32'(sext), 1);
      chk("R10", "nop legal", 32'(ill), 0);
   endtask

   task automatic t_fields;
      drive(mk(5'b01011, 4'b0101, 3'b110, {3'b011, 9'b0}));
      chk("R1", "ra", 32'(ra), 5);
      chk("R1", "rd", 32'(rd), 6);
      chk("R1", "rb", 32'(rb), 3);
      chk("R3", "xor op", 32'(op), 5);
      chk("R10", "xor legal", 32'(ill), 0);
   endtask

   task automatic t_alu_ops;
      for (int o = 0; o < 16; o++) begin
         logic [4:0] oc = 5'(o);
         logic [3:0] a = (oc == 5'b00010) ? 4'b1000 : 4'b0010;
         drive(mk(oc, a, 3'd1, 12'h000));
         chk("R3", $sformatf("op for opcode %0d", o), 32'(op), 32'(alu_exp(oc)));
         chk("R5", $sformatf("use_imm for opcode %0d", o), 32'(use_imm), 32'(!oc[0]));
         chk("R2", $sformatf("class for opcode %0d", o), 32'(cls), 0);
      end
   endtask

   task automatic t_lui;
      drive(mk(5'b00010, 4'b1000, 3'd3, 12'hABC));
      chk("R6", "lui imm", 32'(imm), 32'hABC000);
      chk("R6", "lui op", 32'(op), 8);
      chk("R6", "lui legal", 32'(ill), 0);
   endtask

   task automatic t_imm_ext;
      drive(mk(5'b00000, 4'd1, 3'd1, 12'h800));
      chk("R7", "addi sext", 32'(imm), 32'hFFF800);
      drive(mk(5'b01110, 4'd1, 3'd1, 12'h800));
      chk("R7", "andi zext", 32'(imm), 32'h000800);
      drive(mk(5'b00100, 4'd1, 3'd1, 12'hFFF));
      chk("R7", "slli zext", 32'(imm), 32'h000FFF);
      drive(mk(5'b00000, 4'b1100, 3'd1, 12'hF00));
      chk("R7", "mul imm sext", 32'(imm), 32'hFFFF00);
      drive(mk(5'b01000, 4'b1100, 3'd1, 12'hF00));
      chk("R7", "div imm zext", 32'(imm), 32'h000F00);
   endtask

   task automatic t_muldiv;
      for (int s = 0; s < 4; s++) begin
         for (int f = 0; f < 2; f++) begin
            logic [23:0] w = {1'b0, 2'(s), 1'b1, 1'(f), 2'b11, 2'b01, 3'd2, 12'h000};
            drive(w);
            chk("R2", "muldiv class", 32'(cls), 1);
            chk("R4", $sformatf("muldiv op sel %0d", s), 32'(op), 32'(9 + s));
            chk("R4", "muldiv ra", 32'(ra), 5);
            chk("R5", "muldiv use_imm", 32'(use_imm), 32'(f == 0));
         end
      end
      drive({1'b0, 2'b00, 1'b0, 1'b0, 2'b11, 2'b10, 3'd0, 12'h001});
      chk("R4", "muldiv ra low", 32'(ra), 2);
   endtask

   task automatic t_mem;
      for (int k = 0; k < 4; k++) begin
         drive(mk({2'b10, 1'(k >> 1), 1'(k), 1'b0}, 4'd3, 3'd4, 12'hFFE));
         chk("R2", "mem class", 32'(cls), 2);
         chk("R8", "mem store", 32'(st), 32'(k & 1));
         chk("R8", "mem double", 32'(dbl), 32'(k >> 1));
         chk("R8", "mem op", 32'(op), 0);
         chk("R7", "mem offset sext", 32'(imm), 32'hFFFFFE);
         chk("R10", "mem legal", 32'(ill), 0);
      end
   endtask

   task automatic t_ctrl;
      drive(mk(5'b11000, 4'd1, 3'b010, 12'h004));
      chk("R2", "beq class", 32'(cls), 3);
      chk("R9", "beq cond", 32'(cond), 0);
      chk("R9", "beq jump", 32'(jmp), 0);
      chk("R9", "beq op", 32'(op), 1);
      chk("R9", "beq use_imm", 32'(use_imm), 1);
      drive(mk(5'b11101, 4'd2, 3'b001, 12'hFFC));
      chk("R9", "bge cond", 32'(cond), 5);
      chk("R7", "bge sext", 32'(imm), 32'hFFFFFC);
      drive(mk(5'b11110, 4'd2, 3'b000, 12'h010));
      chk("R9", "blt zero not jump", 32'(jmp), 0);
      chk("R9", "blt zero cond", 32'(cond), 6);
      drive(mk(5'b11110, 4'd2, 3'b100, 12'h800));
      chk("R9", "jump imm flag", 32'(jmp), 1);
      chk("R9", "jump imm op", 32'(op), 0);
      chk("R9", "jump imm use_imm", 32'(use_imm), 1);
      chk("R7", "jump imm zext", 32'(imm), 32'h000800);
      drive(mk(5'b11111, 4'd2, 3'b100, {3'd2, 9'h000}));
      chk("R9", "jump reg flag", 32'(jmp), 1);
      chk("R9", "jump reg use_imm", 32'(use_imm), 0);
      chk("R10", "jump reg legal", 32'(ill), 0);
   endtask

   task automatic t_illegal;
      drive(mk(5'b10001, 4'd1, 3'd1, 12'h000));
      chk("R10", "lw reg-offset", 32'(ill), 1);
      drive(mk(5'b10111, 4'd1, 3'd1, 12'h000));
      chk("R10", "sd reg-offset", 32'(ill), 1);
      drive(mk(5'b00010, 4'b0011, 3'd1, 12'h123));
      chk("R10", "lui bad A", 32'(ill), 1);
      drive(mk(5'b10000, 4'b1100, 3'd1, 12'h000));
      chk("R10", "lw A=1100", 32'(ill), 1);
      drive(mk(5'b10000, 4'b1011, 3'd1, 12'h000));
      chk("R10", "lw A=1011", 32'(ill), 0);
      drive(mk(5'b11000, 4'b1111, 3'd1, 12'h000));
      chk("R10", "beq A=1111", 32'(ill), 1);
   endtask

   task automatic t_pad;
      drive(mk(5'b00001, 4'd1, 3'd1, {3'd2, 9'h001}));
      chk("R11", "add pad strict", 32'(ill), 1);
      chk("R11", "add pad lax", 32'(l_ill), 0);
      drive({1'b0, 2'b00, 1'b0, 1'b1, 2'b11, 2'b00, 3'd1, 3'd1, 9'h100});
      chk("R11", "mulu pad strict", 32'(ill), 1);
      chk("R11", "mulu pad lax", 32'(l_ill), 0);
      drive(mk(5'b11111, 4'd2, 3'b100, {3'd2, 9'h040}));
      chk("R11", "jump pad strict", 32'(ill), 1);
      drive(mk(5'b00000, 4'd1, 3'd1, 12'h1FF));
      chk("R11", "addi imm not pad", 32'(ill), 0);
      chk("R11", "addi imm lax", 32'(l_ill), 0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      t_idle();
      t_fields();
      t_alu_ops();
      t_lui();
      t_imm_ext();
      t_muldiv();
      t_mem();
      t_ctrl();
      t_illegal();
      t_pad();
      finish_run();
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end
endmodule